// File: doc/BRIEF.md
# UART Receive Error and Break Statistics

This block sits beside a UART receiver and keeps running statistics on the quality of the received line. Three 16-bit counters record parity errors, framing errors and noise errors, and a fourth counts break conditions. Each of the first three advances by one for each single-cycle strobe the receiver raises. Software may load any counter with a starting value at any time. Hardware then counts on from that value and wraps past 0xFFFF.

The block also watches the line level itself, sampled once per bit period through a bit-rate enable. A break is a run of low bit periods at least one whole character long. The character length comes from the frame format inputs. A break is counted once, however long it lasts. When the line returns high, the length of the break is stored as a number of whole characters. While a break is in progress, framing-error strobes are dropped, because the receiver's garbage characters during a break are not real framing errors.

Top module: `uart_rx_stats`

## Requirements
- R1: Each strobe on `stb_parity`, `stb_framing` or `stb_noise` with no write to the same counter adds one to that counter, visible on the next clock cycle. A counter at 0xFFFF goes to 0x0000.
- R2: A write pulse (`wr_parity`, `wr_framing`, `wr_noise`, `wr_break`) loads `wr_value` into the matching counter, visible on the next clock cycle.
- R3: When a write and a hardware increment reach the same counter in the same cycle, the counter takes the written value.
- R4: The character length in bit periods is 2 + `fmt_data_bits` + `fmt_parity` + `fmt_two_stop`. Here `fmt_data_bits` holds the data bit count (5 to 9) as a plain binary number, and each 1-bit flag adds one bit.
- R5: A break starts when the line is low for as many consecutive bit periods as one character length. `brk_cnt` then rises by exactly one, however long the break lasts. A low run shorter than one character length does not change `brk_cnt`.
- R6: On the first high bit period after a break, `brk_len` takes the number of low bit periods divided by the character length, rounded down. It changes at no other time. A low run shorter than one character leaves it unchanged.
- R7: A `stb_framing` strobe arriving while a break is in progress is ignored. This includes the bit period that completes the first break character. Parity and noise strobes are still counted during a break.
- R8: After reset all four counters and `brk_len` read zero.
- R9: The line level is sampled only in cycles where `bit_tick` is high. Changes of `rxd_level` in other cycles do not affect break detection or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse, once per bit period |
| rxd_level | input | 1 | Receive line level |
| fmt_data_bits | input | 4 | Data bits per character (5 to 9) |
| fmt_parity | input | 1 | Parity bit present |
| fmt_two_stop | input | 1 | Second stop bit present |
| stb_parity | input | 1 | Parity error strobe |
| stb_framing | input | 1 | Framing error strobe |
| stb_noise | input | 1 | Noise error strobe |
| wr_parity | input | 1 | Load parity error counter |
| wr_framing | input | 1 | Load framing error counter |
| wr_noise | input | 1 | Load noise error counter |
| wr_break | input | 1 | Load break counter |
| wr_value | input | 16 | Value to load |
| par_cnt | output | 16 | Parity error count |
| frm_cnt | output | 16 | Framing error count |
| nse_cnt | output | 16 | Noise error count |
| brk_cnt | output | 16 | Break condition count |
| brk_len | output | 16 | Length of the last break in characters |

## Verification
The properties assume that `bit_tick` is a single-cycle pulse. They also assume that the frame format stays constant while the line is low, since the character length may not change in the middle of a break. The stimulus changes the format only while the line has been idle high for several bit periods. It spaces bit ticks two clocks apart and drives error strobes as one-cycle pulses. The sweep covers all twenty legal format combinations. For each one, the stimulus places low runs just under one character, exactly one character, and past two characters. One long run also toggles the line between ticks.

// File: rtl/uart_stats_pkg.sv
package uart_stats_pkg;
  localparam int FMT_LEN_W = 4;
  localparam int NUM_CNT   = 4;
  localparam int IDX_PAR   = 0;
  localparam int IDX_FRM   = 1;
  localparam int IDX_NSE   = 2;
  localparam int IDX_BRK   = 3;

  // Character length in bit periods: start + data + optional parity + stop(s)
  function automatic logic [FMT_LEN_W-1:0] frame_bits(
    input logic [FMT_LEN_W-1:0] data_bits,
    input logic                 parity,
    input logic                 two_stop);
    return data_bits + FMT_LEN_W'(2) + FMT_LEN_W'(parity) + FMT_LEN_W'(two_stop);
  endfunction
endpackage

// File: rtl/uart_stat_counter.sv
module uart_stat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (wr)  q <= wdata;       // software load has priority
    else if (inc) q <= q + CNT_W'(1);
  end
endmodule

// File: rtl/uart_break_meter.sv
module uart_break_meter #(
  parameter int LEN_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             line,
  input  logic [LEN_W-1:0] char_len,
  output logic             start_now,
  output logic             in_break,
  output logic             brk_pulse,
  output logic [CNT_W-1:0] brk_len
);
  localparam logic [CNT_W-1:0] CHAR_MAX = '1;

  logic [LEN_W-1:0] bit_ph;
  logic [CNT_W-1:0] chars;
  logic             roll;

  assign roll      = (bit_ph == char_len - LEN_W'(1));
  assign start_now = tick & ~line & roll & (chars == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_ph    <= '0;
      chars     <= '0;
      in_break  <= 1'b0;
      brk_pulse <= 1'b0;
      brk_len   <= '0;
    end else begin
      brk_pulse <= 1'b0;
      if (tick) begin
        if (!line) begin
          if (roll) begin
            bit_ph <= '0;
            if (chars != CHAR_MAX) chars <= chars + CNT_W'(1);
            if (chars == '0) begin
              in_break  <= 1'b1;
              brk_pulse <= 1'b1;
            end
          end else begin
            bit_ph <= bit_ph + LEN_W'(1);
          end
        end else begin
          if (in_break) brk_len <= chars;
          bit_ph   <= '0;
          chars    <= '0;
          in_break <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_stats.sv
module uart_rx_stats
  import uart_stats_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_tick,
  input  logic                 rxd_level,
  input  logic [FMT_LEN_W-1:0] fmt_data_bits,
  input  logic                 fmt_parity,
  input  logic                 fmt_two_stop,
  input  logic                 stb_parity,
  input  logic                 stb_framing,
  input  logic                 stb_noise,
  input  logic                 wr_parity,
  input  logic                 wr_framing,
  input  logic                 wr_noise,
  input  logic                 wr_break,
  input  logic [CNT_W-1:0]     wr_value,
  output logic [CNT_W-1:0]     par_cnt,
  output logic [CNT_W-1:0]     frm_cnt,
  output logic [CNT_W-1:0]     nse_cnt,
  output logic [CNT_W-1:0]     brk_cnt,
  output logic [CNT_W-1:0]     brk_len
);
  logic [FMT_LEN_W-1:0] char_len;
  logic                 start_now, in_break, brk_pulse, brk_active;
  logic [NUM_CNT-1:0]   inc_v, wr_v;
  logic [CNT_W-1:0]     cnt_q [NUM_CNT];

  assign char_len   = frame_bits(fmt_data_bits, fmt_parity, fmt_two_stop);
  assign brk_active = in_break | start_now;

  uart_break_meter #(.LEN_W(FMT_LEN_W), .CNT_W(CNT_W)) u_meter (
    .clk       (clk),
    .rst       (rst),
    .tick      (bit_tick),
    .line      (rxd_level),
    .char_len  (char_len),
    .start_now (start_now),
    .in_break  (in_break),
    .brk_pulse (brk_pulse),
    .brk_len   (brk_len)
  );

  assign inc_v[IDX_PAR] = stb_parity;
  assign inc_v[IDX_FRM] = stb_framing & ~brk_active;
  assign inc_v[IDX_NSE] = stb_noise;
  assign inc_v[IDX_BRK] = brk_pulse;
  assign wr_v[IDX_PAR]  = wr_parity;
  assign wr_v[IDX_FRM]  = wr_framing;
  assign wr_v[IDX_NSE]  = wr_noise;
  assign wr_v[IDX_BRK]  = wr_break;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    uart_stat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (inc_v[g]),
      .wr    (wr_v[g]),
      .wdata (wr_value),
      .q     (cnt_q[g])
    );
  end

  assign par_cnt = cnt_q[IDX_PAR];
  assign frm_cnt = cnt_q[IDX_FRM];
  assign nse_cnt = cnt_q[IDX_NSE];
  assign brk_cnt = cnt_q[IDX_BRK];
endmodule

// File: rtl/uart_rx_stats_chk.sv
module uart_rx_stats_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             rxd,
  input logic             stb_parity,
  input logic             stb_framing,
  input logic             wr_parity,
  input logic             wr_framing,
  input logic             wr_break,
  input logic [CNT_W-1:0] wr_value,
  input logic             brk_active,
  input logic             in_break,
  input logic             brk_pulse,
  input logic [CNT_W-1:0] par_cnt,
  input logic [CNT_W-1:0] frm_cnt,
  input logic [CNT_W-1:0] brk_cnt,
  input logic [CNT_W-1:0] brk_len
);
  assert_par_inc_R1: assert property (@(posedge clk) disable iff (rst)
    (stb_parity && !wr_parity) |=> par_cnt == CNT_W'($past(par_cnt) + CNT_W'(1)));

  assert_par_load_R2: assert property (@(posedge clk) disable iff (rst)
    wr_parity |=> par_cnt == $past(wr_value));

  assert_write_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_framing && stb_framing) |=> frm_cnt == $past(wr_value));

  assert_once_per_break_R5: assert property (@(posedge clk) disable iff (rst)
    $past(in_break) |-> !brk_pulse);

  assert_brk_count_R5: assert property (@(posedge clk) disable iff (rst)
    (brk_pulse && !wr_break) |=> brk_cnt == CNT_W'($past(brk_cnt) + CNT_W'(1)));

  assert_len_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(tick && rxd) |=> $stable(brk_len));

  assert_frm_mask_R7: assert property (@(posedge clk) disable iff (rst)
    (stb_framing && brk_active && !wr_framing) |=> $stable(frm_cnt));

  assert_tick_only_R9: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(in_break));
endmodule

bind uart_rx_stats uart_rx_stats_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (bit_tick),
  .rxd         (rxd_level),
  .stb_parity  (stb_parity),
  .stb_framing (stb_framing),
  .wr_parity   (wr_parity),
  .wr_framing  (wr_framing),
  .wr_break    (wr_break),
  .wr_value    (wr_value),
  .brk_active  (brk_active),
  .in_break    (in_break),
  .brk_pulse   (brk_pulse),
  .par_cnt     (par_cnt),
  .frm_cnt     (frm_cnt),
  .brk_cnt     (brk_cnt),
  .brk_len     (brk_len)
);

// File: tb/uart_rx_stats_tb.sv
module uart_rx_stats_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_tick = 1'b0, rxd_level = 1'b1;
  logic [3:0]  fmt_data_bits = 4'd8;
  logic        fmt_parity = 1'b0, fmt_two_stop = 1'b0;
  logic        stb_parity = 1'b0, stb_framing = 1'b0, stb_noise = 1'b0;
  logic        wr_parity = 1'b0, wr_framing = 1'b0, wr_noise = 1'b0, wr_break = 1'b0;
  logic [15:0] wr_value = '0;
  logic [15:0] par_cnt, frm_cnt, nse_cnt, brk_cnt, brk_len;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] exp_c [4];
  logic [15:0] exp_len;

  always #10 clk = ~clk;

  uart_rx_stats u_dut (.*);

  function automatic logic [15:0] cnt_of(input int i);
    case (i)
      0: return par_cnt;
      1: return frm_cnt;
      2: return nse_cnt;
      default: return brk_cnt;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_stb(input int i, input logic v);
    case (i)
      0: stb_parity = v;
      1: stb_framing = v;
      default: stb_noise = v;
    endcase
  endtask

  task automatic set_wr(input int i, input logic v);
    case (i)
      0: wr_parity = v;
      1: wr_framing = v;
      2: wr_noise = v;
      default: wr_break = v;
    endcase
  endtask

  task automatic ticks(input logic lvl, input int n);
    for (int k = 0; k < n; k++) begin
      rxd_level = lvl; bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic check_break(input string req);
    repeat (2) @(negedge clk);
    check({req, " brk_cnt"}, brk_cnt, exp_c[3]);
    check({req, " brk_len"}, brk_len, exp_len);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) exp_c[i] = '0;
    exp_len = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    for (int i = 0; i < 4; i++) check("R8 reset counter", cnt_of(i), 16'h0000);
    check("R8 reset brk_len", brk_len, 16'h0000);

    // Error counters: load, wrap, write-wins
    for (int i = 0; i < 3; i++) begin
      wr_value = 16'hFFFE; set_wr(i, 1'b1);
      @(negedge clk); set_wr(i, 1'b0);
      check("R2 load", cnt_of(i), 16'hFFFE);
      set_stb(i, 1'b1); @(negedge clk); set_stb(i, 1'b0);
      check("R1 increment", cnt_of(i), 16'hFFFF);
      set_stb(i, 1'b1); @(negedge clk); set_stb(i, 1'b0);
      check("R1 wrap", cnt_of(i), 16'h0000);
      wr_value = 16'h1234 + 16'(i); set_wr(i, 1'b1); set_stb(i, 1'b1);
      @(negedge clk); set_wr(i, 1'b0); set_stb(i, 1'b0);
      check("R3 write wins", cnt_of(i), 16'h1234 + 16'(i));
      set_stb(i, 1'b1); @(negedge clk); set_stb(i, 1'b0);
      check("R1 after load", cnt_of(i), 16'h1235 + 16'(i));
      exp_c[i] = 16'h1235 + 16'(i);
    end

    // Break counter: wrap through a real break, then write-wins
    wr_value = 16'hFFFF; wr_break = 1'b1; @(negedge clk); wr_break = 1'b0;
    check("R2 load brk", brk_cnt, 16'hFFFF);
    ticks(1'b0, 10); ticks(1'b1, 1);
    exp_c[3] = 16'h0000; exp_len = 16'd1;
    check_break("R1 R5 brk wrap");
    ticks(1'b0, 9);
    rxd_level = 1'b0; bit_tick = 1'b1; @(negedge clk);
    bit_tick = 1'b0; wr_break = 1'b1; wr_value = 16'h00AA; @(negedge clk);
    wr_break = 1'b0;
    check("R3 brk write wins", brk_cnt, 16'h00AA);
    exp_c[3] = 16'h00AA;
    ticks(1'b0, 3); ticks(1'b1, 1);
    exp_len = 16'd1;
    check_break("R6 after write");

    // Sweep all legal frame formats
    for (int d = 5; d <= 9; d++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 2; s++) begin
          int cl;
          ticks(1'b1, 2);
          fmt_data_bits = 4'(d); fmt_parity = 1'(p); fmt_two_stop = 1'(s);
          cl = 2 + d + p + s;   // R4
          ticks(1'b1, 2);
          ticks(1'b0, cl - 1); ticks(1'b1, 1);
          check_break("R4 R5 R6 short run");
          ticks(1'b0, cl); ticks(1'b1, 1);
          exp_c[3] = exp_c[3] + 16'd1; exp_len = 16'd1;
          check_break("R4 R5 R6 one char");
          ticks(1'b0, cl + 2);
          rxd_level = 1'b1; repeat (3) @(negedge clk);  // R9: no tick
          ticks(1'b0, cl + 1); ticks(1'b1, 1);
          exp_c[3] = exp_c[3] + 16'd1; exp_len = 16'((2 * cl + 3) / cl);
          check_break("R5 R6 R9 long run");
        end

    // R7: framing strobes masked during break
    ticks(1'b1, 2);
    fmt_data_bits = 4'd8; fmt_parity = 1'b0; fmt_two_stop = 1'b0;
    ticks(1'b1, 2);
    ticks(1'b0, 9);
    rxd_level = 1'b0; bit_tick = 1'b1; stb_framing = 1'b1; @(negedge clk);
    bit_tick = 1'b0; stb_framing = 1'b0; @(negedge clk);
    check("R7 frm at break start", frm_cnt, exp_c[1]);
    stb_framing = 1'b1; stb_noise = 1'b1; stb_parity = 1'b1; @(negedge clk);
    stb_framing = 1'b0; stb_noise = 1'b0; stb_parity = 1'b0; @(negedge clk);
    check("R7 frm in break", frm_cnt, exp_c[1]);
    exp_c[2] = exp_c[2] + 16'd1; exp_c[0] = exp_c[0] + 16'd1;
    check("R7 noise in break", nse_cnt, exp_c[2]);
    check("R7 parity in break", par_cnt, exp_c[0]);
    ticks(1'b1, 1);
    exp_c[3] = exp_c[3] + 16'd1; exp_len = 16'd1;
    check_break("R5 R6 masked break");
    stb_framing = 1'b1; @(negedge clk); stb_framing = 1'b0;
    exp_c[1] = exp_c[1] + 16'd1;
    check("R7 frm after break", frm_cnt, exp_c[1]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule